// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Threshold Flags

This block is a first-in first-out buffer of 18-bit words. It sits between a producer clocked by a write clock and a consumer clocked by a read clock. The two clocks may be the same net or may run with no fixed relation. Each side has an active-low enable that is sampled on its own rising edge. The read data leaves through a register, and an active-low output enable releases the data pins to high impedance.

Five active-low status outputs report the fill state: empty, almost empty, half full, almost full and full. The two "almost" thresholds are offsets held in registers. Reset sets both offsets to 127, and a load strobe on the write side can overwrite either one. A mode input selects how the almost flags are produced. They can come straight from both live pointers, or they can be registered in their own clock domain. A rewind input moves the read pointer back to storage location 0, so every word written since reset can be read out again.

Top module: `twin_clock_fifo`

## Requirements
- R1: A word is stored on a `wrClk` rising edge when `wrEnN` is low, and a word is taken on a `rdClk` rising edge when `rdEnN` is low. Words come out in the order they were written. The word taken appears on `rdData` just after the read edge that takes it.
- R2: While `outEnN` is high, `rdData` is released to high impedance. While it is low, `rdData` shows the last word read.
- R3: `emptyN` is low when no word is stored and goes low right after the read edge that takes the last word. `fullN` is low when DEPTH words are stored and goes low right after the write edge that stores the last free slot. Each flag is released on the second edge of its own clock after the other side has moved.
- R4: `halfFullN` is low when more than DEPTH/2 words are stored and high when DEPTH/2 or fewer are stored. It is worked out from both live pointers, so it changes right after either edge.
- R5: `almostEmptyN` is low when the count is at most the empty offset n. `almostFullN` is low when the count is at least DEPTH − m, where m is the full offset. After reset, n = 127 and m = 127.
- R6: When `offLoad` is high on a `wrClk` edge, `wrData[AW-1:0]` is copied into n if `offSel` = 0, or into m if `offSel` = 1. No word is stored on that edge, whatever `wrEnN` is.
- R7: A write requested while `fullN` is low is ignored. The word is not stored and nothing is lost.
- R8: A read requested while `emptyN` is low is ignored, and `rdData` keeps the previous word.
- R9: When `retransN` is low on a `rdClk` edge, the read pointer returns to location 0 and no word is taken on that edge. Later reads then replay every word written since reset. This holds as long as no more than DEPTH words have been written since reset and the write side stays idle around the rewind.
- R10: With `syncMode` = 0, the almost flags follow the live pointers and change right after either edge. With `syncMode` = 1, `almostEmptyN` is registered on `rdClk` and `almostFullN` on `wrClk`. Each one lags a change made on its own side by one edge, and a change made on the other side by three edges of its own clock.
- R11: Reset (`resetN` low) is asynchronous and empties the buffer. Afterwards `emptyN` = 0, `almostEmptyN` = 0, `halfFullN` = 1, `almostFullN` = 1, `fullN` = 1, and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| resetN | input | 1 | Asynchronous reset, active low |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | WIDTH | Write word; low AW bits also carry an offset value |
| rdEnN | input | 1 | Read enable, active low |
| outEnN | input | 1 | Output enable, active low; high releases rdData |
| retransN | input | 1 | Rewind read pointer to location 0, active low, rdClk domain |
| offLoad | input | 1 | Offset load strobe, wrClk domain |
| offSel | input | 1 | Offset select: 0 almost-empty n, 1 almost-full m |
| syncMode | input | 1 | 0: almost flags from live pointers; 1: registered per domain |
| rdData | output | WIDTH | Registered read word, high impedance when disabled |
| emptyN | output | 1 | Empty, active low |
| almostEmptyN | output | 1 | Almost empty, active low |
| halfFullN | output | 1 | Half full, active low |
| almostFullN | output | 1 | Almost full, active low |
| fullN | output | 1 | Full, active low |

## Verification
The read word is due just after the edge that takes it. The half-full flag and the live almost flags, as well as full on a write and empty on a read, also respond on that same edge. Empty and full are released two edges after the far side moves, and the registered almost flags follow one edge after that. The bench drives its inputs on falling edges and compares data right after each read edge. It compares the flags against the count in its queue model only after six idle cycles, so every crossing has settled. A small set of directed checks samples the flags at the exact edge where each one is due to change, or due to stay put.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  // Per-cycle commands from the pointer control to the storage array.
  typedef struct packed {
    logic wrStb;   // store wrData at the write address (wrClk domain)
    logic rdStb;   // load the output register from the read address (rdClk domain)
  } tcfStrobe_t;

  // Which threshold register a load strobe targets.
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } offSel_e;

endpackage

// File: rtl/tcf_sync.sv
module tcf_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         resetN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/tcf_ctrl.sv
module tcf_ctrl import tcf_pkg::*; #(
  parameter int AW         = 9,
  parameter int AE_DEFAULT = 127,
  parameter int AF_DEFAULT = 127,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          resetN,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          retransN,
  input  logic          offLoad,
  input  logic          offSel,
  input  logic [AW-1:0] offData,
  input  logic          syncMode,
  output tcfStrobe_t    strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyN,
  output logic          almostEmptyN,
  output logic          halfFullN,
  output logic          almostFullN,
  output logic          fullN
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;
  localparam logic [PW-1:0] HALF_P  = PW'(1) << (AW - 1);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wrPtrBin, wrPtrGray, rdPtrBin, rdPtrGray;
  logic [PW-1:0] rdGrayAtWr, wrGrayAtRd;
  logic [PW-1:0] wrCount, rdCount, liveCount;
  logic          fullInt, emptyInt, wrAccept, rdAccept, rewind;
  logic [AW-1:0] aeOff, afOff;
  logic          aeSyncQ, afSyncQ, aeLive, afLive;

  // Gray pointers cross into the opposite domain.
  tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .resetN(resetN), .din(rdPtrGray), .dout(rdGrayAtWr)
  );
  tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .resetN(resetN), .din(wrPtrGray), .dout(wrGrayAtRd)
  );

  // Occupancy as seen from each side, plus the live cross-domain count.
  always_comb begin
    wrCount   = wrPtrBin - fromGray(rdGrayAtWr);
    rdCount   = fromGray(wrGrayAtRd) - rdPtrBin;
    liveCount = wrPtrBin - rdPtrBin;
    fullInt   = (wrCount == DEPTH_P);
    emptyInt  = (rdCount == '0);
    rewind    = !retransN;
    wrAccept  = !wrEnN && !offLoad && !fullInt;
    rdAccept  = !rdEnN && !rewind && !emptyInt;
  end

  // Write pointer.
  always_ff @(posedge wrClk or negedge resetN) begin
    if (!resetN) begin
      wrPtrBin  <= '0;
      wrPtrGray <= '0;
    end else if (wrAccept) begin
      wrPtrBin  <= wrPtrBin + PW'(1);
      wrPtrGray <= toGray(wrPtrBin + PW'(1));
    end
  end

  // Read pointer with rewind.
  always_ff @(posedge rdClk or negedge resetN) begin
    if (!resetN) begin
      rdPtrBin  <= '0;
      rdPtrGray <= '0;
    end else if (rewind) begin
      rdPtrBin  <= '0;
      rdPtrGray <= '0;
    end else if (rdAccept) begin
      rdPtrBin  <= rdPtrBin + PW'(1);
      rdPtrGray <= toGray(rdPtrBin + PW'(1));
    end
  end

  // Threshold registers, loaded from the write side.
  always_ff @(posedge wrClk or negedge resetN) begin
    if (!resetN) begin
      aeOff <= AW'(AE_DEFAULT);
      afOff <= AW'(AF_DEFAULT);
    end else if (offLoad) begin
      if (offSel_e'(offSel) == SEL_AF) afOff <= offData;
      else                             aeOff <= offData;
    end
  end

  // Live almost flags (asserted level is 1 internally).
  always_comb begin
    aeLive = (liveCount <= {1'b0, aeOff});
    afLive = (liveCount >= (DEPTH_P - {1'b0, afOff}));
  end

  // Registered almost flags, each in its own domain.
  always_ff @(posedge rdClk or negedge resetN) begin
    if (!resetN) aeSyncQ <= 1'b1;
    else         aeSyncQ <= (rdCount <= {1'b0, aeOff});
  end

  always_ff @(posedge wrClk or negedge resetN) begin
    if (!resetN) afSyncQ <= 1'b0;
    else         afSyncQ <= (wrCount >= (DEPTH_P - {1'b0, afOff}));
  end

  always_comb begin
    emptyN       = !emptyInt;
    fullN        = !fullInt;
    halfFullN    = !(liveCount > HALF_P);
    almostEmptyN = !(syncMode ? aeSyncQ : aeLive);
    almostFullN  = !(syncMode ? afSyncQ : afLive);
    strobe.wrStb = wrAccept;
    strobe.rdStb = rdAccept;
    wrAddr       = wrPtrBin[AW-1:0];
    rdAddr       = rdPtrBin[AW-1:0];
  end

  // R7
  full_blocks_write_chk: assert property (@(posedge wrClk) disable iff (!resetN)
    fullInt |=> $stable(wrPtrBin));

  // R8
  empty_blocks_read_chk: assert property (@(posedge rdClk) disable iff (!resetN)
    (emptyInt && retransN) |=> $stable(rdPtrBin));

  // R9
  rewind_to_zero_chk: assert property (@(posedge rdClk) disable iff (!resetN)
    !retransN |=> (rdPtrBin == '0));

  // R6
  load_no_write_chk: assert property (@(posedge wrClk) disable iff (!resetN)
    offLoad |=> $stable(wrPtrBin));

  // R3
  count_bound_chk: assert property (@(posedge wrClk) disable iff (!resetN)
    wrCount <= DEPTH_P);

endmodule

// File: rtl/tcf_store.sv
module tcf_store import tcf_pkg::*; #(
  parameter int WIDTH = 18,
  parameter int AW    = 9
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             resetN,
  input  tcfStrobe_t       strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] qWord
);

  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge resetN) begin
    if (!resetN)          qWord <= '0;
    else if (strobe.rdStb) qWord <= mem[rdAddr];
  end

  // R8
  hold_output_chk: assert property (@(posedge rdClk) disable iff (!resetN)
    !strobe.rdStb |=> $stable(qWord));

endmodule

// File: rtl/twin_clock_fifo.sv
module twin_clock_fifo import tcf_pkg::*; #(
  parameter int WIDTH      = 18,
  parameter int AW         = 9,
  parameter int AE_DEFAULT = 127,
  parameter int AF_DEFAULT = 127
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             resetN,
  input  logic             wrEnN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEnN,
  input  logic             outEnN,
  input  logic             retransN,
  input  logic             offLoad,
  input  logic             offSel,
  input  logic             syncMode,
  output logic [WIDTH-1:0] rdData,
  output logic             emptyN,
  output logic             almostEmptyN,
  output logic             halfFullN,
  output logic             almostFullN,
  output logic             fullN
);

  tcfStrobe_t       strobe;
  logic [AW-1:0]    wrAddr, rdAddr;
  logic [WIDTH-1:0] qWord;

  tcf_ctrl #(
    .AW(AW), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT), .SYNC_STAGES(2)
  ) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .resetN(resetN),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .retransN(retransN),
    .offLoad(offLoad), .offSel(offSel), .offData(wrData[AW-1:0]),
    .syncMode(syncMode),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN), .halfFullN(halfFullN),
    .almostFullN(almostFullN), .fullN(fullN)
  );

  tcf_store #(.WIDTH(WIDTH), .AW(AW)) u_store (
    .wrClk(wrClk), .rdClk(rdClk), .resetN(resetN),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .qWord(qWord)
  );

  assign rdData = outEnN ? {WIDTH{1'bz}} : qWord;

endmodule

// File: tb/twin_clock_fifo_bench.sv
module twin_clock_fifo_bench;
  localparam int W = 18, AW = 9, DEPTH = 1 << AW, HALF = DEPTH / 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic resetN = 1'b0, wrEnN = 1'b1, rdEnN = 1'b1, outEnN = 1'b0;
  logic retransN = 1'b1, offLoad = 1'b0, offSel = 1'b0, syncMode = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic emptyN, almostEmptyN, halfFullN, almostFullN, fullN;

  twin_clock_fifo #(.WIDTH(W), .AW(AW)) u_twin_clock_fifo (
    .wrClk(clk), .rdClk(clk), .resetN(resetN), .wrEnN(wrEnN), .wrData(wrData),
    .rdEnN(rdEnN), .outEnN(outEnN), .retransN(retransN), .offLoad(offLoad),
    .offSel(offSel), .syncMode(syncMode), .rdData(rdData), .emptyN(emptyN),
    .almostEmptyN(almostEmptyN), .halfFullN(halfFullN),
    .almostFullN(almostFullN), .fullN(fullN)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] hist[$];
  int aeOff = 127, afOff = 127;
  logic [W-1:0] lastWord = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, want);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit we, input bit re, input logic [W-1:0] d);
    bit fOk, eOk;
    logic [W-1:0] want;
    fOk = fullN; eOk = emptyN;
    wrEnN = !we; rdEnN = !re; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEnN = 1'b1; rdEnN = 1'b1;
    if (re && eOk) begin
      want = q.pop_front();
      lastWord = want;
      chk(rdData === want, "R1 read order", rdData, want);
    end
    if (we && fOk) begin q.push_back(d); hist.push_back(d); end
  endtask

  task automatic settle(input string tag);
    int c;
    repeat (6) step(0, 0, '0);
    c = q.size();
    chk(emptyN === (c != 0), {tag, " R3 emptyN"}, emptyN, c != 0);
    chk(fullN === (c != DEPTH), {tag, " R3 fullN"}, fullN, c != DEPTH);
    chk(halfFullN === !(c > HALF), {tag, " R4 halfFullN"}, halfFullN, !(c > HALF));
    chk(almostEmptyN === !(c <= aeOff), {tag, " R5 almostEmptyN"}, almostEmptyN, !(c <= aeOff));
    chk(almostFullN === !(c >= DEPTH - afOff), {tag, " R5 almostFullN"}, almostFullN,
        !(c >= DEPTH - afOff));
  endtask

  task automatic loadOff(input bit sel, input int val);
    offLoad = 1'b1; offSel = sel; wrData = W'(val); wrEnN = 1'b0;   // R6 write also requested
    @(posedge clk); @(negedge clk);
    offLoad = 1'b0; wrEnN = 1'b1;
    if (sel) afOff = val; else aeOff = val;
  endtask

  task automatic doReset();
    resetN = 1'b0; wrEnN = 1'b1; rdEnN = 1'b1; retransN = 1'b1; offLoad = 1'b0;
    q.delete(); hist.delete(); aeOff = 127; afOff = 127; lastWord = '0;
    repeat (2) @(negedge clk);
    resetN = 1'b1;
  endtask

  initial begin : main
    int seedDummy;
    int prev;
    seedDummy = $urandom(32'h5eed);
    @(negedge clk);
    doReset();
    // R11 reset state
    chk(emptyN === 1'b0, "R11 emptyN", emptyN, 0);
    chk(almostEmptyN === 1'b0, "R11 almostEmptyN", almostEmptyN, 0);
    chk(halfFullN === 1'b1, "R11 halfFullN", halfFullN, 1);
    chk(almostFullN === 1'b1, "R11 almostFullN", almostFullN, 1);
    chk(fullN === 1'b1, "R11 fullN", fullN, 1);
    chk(rdData === '0, "R11 rdData", rdData, 0);

    // Random traffic, live almost flags, default offsets (R1 R5)
    for (int i = 0; i < 1500; i++) begin
      step($urandom_range(99) < 65, $urandom_range(99) < 35, W'($urandom));
      if (i % 100 == 99) settle("fill");
    end
    for (int i = 0; i < 1500; i++) begin
      step($urandom_range(99) < 30, $urandom_range(99) < 75, W'($urandom));
      if (i % 100 == 99) settle("drain");
    end

    // Directed fill: half-full and full edges (R3 R4 R7)
    doReset();
    for (int i = 0; i < DEPTH + 4; i++) begin
      prev = q.size();
      step(1, 0, W'($urandom));
      if (q.size() == HALF && prev != HALF) chk(halfFullN === 1'b1, "R4 at half", halfFullN, 1);
      if (q.size() == HALF + 1 && prev == HALF) chk(halfFullN === 1'b0, "R4 above half", halfFullN, 0);
      if (q.size() == DEPTH && prev == DEPTH - 1) chk(fullN === 1'b0, "R3 full same edge", fullN, 0);
    end
    settle("full");
    for (int i = 0; i < 3; i++) step(1, 0, 18'h3FFFF);
    chk(fullN === 1'b0, "R7 still full", fullN, 0);
    while (q.size() > 0) begin
      step(0, 1, '0);
      if (q.size() == 0) chk(emptyN === 1'b0, "R3 empty same edge", emptyN, 1'b0);
    end
    settle("R7 drained");
    // R8 read while empty
    prev = lastWord;
    step(0, 1, '0);
    chk(rdData === W'(prev), "R8 hold on empty read", rdData, prev);
    // R2 output enable
    step(1, 0, 18'h2A5A5);
    settle("R2 prep");
    step(0, 1, '0);
    outEnN = 1'b1; #2;
    chk(rdData !== 18'h2A5A5, "R2 released", rdData, 0);
    outEnN = 1'b0; #2;
    chk(rdData === 18'h2A5A5, "R2 driven", rdData, 18'h2A5A5);

    // Offset load and threshold edges (R5 R6)
    doReset();
    loadOff(0, 5);
    loadOff(1, 10);
    settle("R6 load no write");
    for (int k = 0; k < 8; k++) begin step(1, 0, W'($urandom)); settle("R5 ae edge"); end
    while (q.size() < DEPTH - 13) step(1, 0, W'($urandom));
    for (int k = 0; k < 6; k++) begin step(1, 0, W'($urandom)); settle("R5 af edge"); end

    // Flag mode timing (R10)
    doReset();
    syncMode = 1'b0;
    loadOff(0, 3);
    for (int k = 0; k < 3; k++) step(1, 0, W'($urandom));
    settle("R10 live");
    step(1, 0, W'($urandom));
    chk(almostEmptyN === 1'b1, "R10 live immediate", almostEmptyN, 1);
    step(0, 1, '0);
    syncMode = 1'b1;
    settle("R10 sync");
    step(1, 0, W'($urandom));
    chk(almostEmptyN === 1'b0, "R10 sync far-side lag", almostEmptyN, 0);
    settle("R10 sync after");
    step(0, 1, '0);
    chk(almostEmptyN === 1'b1, "R10 sync own lag", almostEmptyN, 1);
    step(0, 0, '0);
    chk(almostEmptyN === 1'b0, "R10 sync own update", almostEmptyN, 0);

    // Random traffic with registered flags and custom offsets (R5 R10)
    loadOff(0, 40);
    loadOff(1, 50);
    for (int i = 0; i < 1200; i++) begin
      step($urandom_range(99) < 55, $urandom_range(99) < 45, W'($urandom));
      if (i % 100 == 99) settle("sync rand");
    end

    // Retransmit (R9)
    doReset();
    syncMode = 1'b0;
    for (int k = 0; k < 20; k++) step(1, 0, W'($urandom));
    settle("R9 prep");
    for (int k = 0; k < 8; k++) step(0, 1, '0);
    prev = lastWord;
    retransN = 1'b0; rdEnN = 1'b0;
    @(posedge clk); @(negedge clk);
    retransN = 1'b1; rdEnN = 1'b1;
    chk(rdData === W'(prev), "R9 no read on rewind", rdData, prev);
    q = hist;
    settle("R9 rewound");
    for (int k = 0; k < 20; k++) step(0, 1, '0);
    settle("R9 replayed");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule